// File: doc/BRIEF.md
# Power switch fault supervisor

This block is the digital controller behind a current-limited power switch that feeds an external bus. It watches six comparator flags (over temperature, over current, short circuit, reverse current, bus overvoltage and input undervoltage). An enable input and a one-millisecond tick from a shared prescaler complete its inputs. From these it decides when the switch may conduct, drives an active-low fault flag and reports an encoded fault cause.

All timing is counted in ticks, so every window is a whole number of milliseconds. A qualified delay of 16 ticks precedes each turn-on, and over-current detection is blanked just after enable. Over current and reverse current must persist before they count. A short circuit is handled with a fixed regulate-then-rest hiccup cycle. No fault latches: once the inputs are clean again, the block counts a recovery delay and turns the switch back on by itself.

Cause codes: 0 normal (switch on), 1 over temperature, 2 over current or short circuit, 3 reverse current, 4 bus overvoltage, 5 input undervoltage, 6 pending (no fault, waiting to turn on), 7 disabled. All control and status pins are plain level signals; there is no streamed data and no handshake.

Top module: `pwr_switch_supervisor`

## Requirements
- R1: One clock after enable is seen low, the switch is off, the fault flag is low and the cause is 7; any count in progress is dropped, so the next enable starts a fresh 16-tick wait.
- R2: While enabled, over temperature, bus overvoltage or input undervoltage turns the switch off one clock later and drives the fault flag low, with cause 1, 4 or 5 respectively.
- R3: Faults never latch: after an over-temperature fault clears, the switch turns back on by itself once 16 clean ticks have passed, and the fault flag returns high.
- R4: After enable the switch turns on on the 16th tick that arrives with all conditions clean. While waiting, cause is 6 and the flag stays high. Any fault during the wait restarts the count.
- R5: When several faults are present the cause reports the highest one, in the order over temperature, over current or short, reverse current, bus overvoltage, input undervoltage.
- R6: The over-current flag is ignored for the first 4 ticks after enable; its persistence count only begins after that window.
- R7: With the switch on, the over-current flag must stay high for 10 consecutive ticks before the switch turns off with cause 2.
- R8: A short circuit with the switch on keeps it conducting in regulation, with the flag low and cause 2. After 13 ticks it turns off. It retries on the 153rd tick counted from the start of the regulation pulse.
- R9: After an undervoltage fault clears, 18 clean ticks are needed before the switch turns on again and the flag rises. After an overvoltage fault, 9 are needed.
- R10: A reverse-current flag held for 18 consecutive ticks turns the switch off with cause 3; a shorter one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Switch enable request |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| ot_i | input | 1 | Over-temperature flag |
| oc_i | input | 1 | Over-current flag |
| sc_i | input | 1 | Short-circuit flag |
| rev_i | input | 1 | Reverse-current flag (bus above input) |
| ov_i | input | 1 | Bus overvoltage flag |
| uv_i | input | 1 | Input undervoltage flag |
| sw_on_o | output | 1 | Switch conduct command |
| fault_n_o | output | 1 | Fault flag, low on fault or disable |
| cause_o | output | 3 | Encoded fault cause |

## Verification
A wrong wait or hiccup count shows as the switch command changing one tick early or late. The bench therefore samples one tick before and exactly at each boundary, so the error is caught within a single tick. A broken priority encoder or a wrong recovery-delay selection shows on the cause code one clock after the faults are applied, or as a turn-on at the wrong tick after release. A stuck blanking or persistence counter moves the fault instant by several ticks, and the check on the earlier tick exposes it.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    CZ_NORMAL = 3'd0,
    CZ_OTEMP  = 3'd1,
    CZ_OCUR   = 3'd2,
    CZ_REV    = 3'd3,
    CZ_OVOLT  = 3'd4,
    CZ_UVOLT  = 3'd5,
    CZ_PEND   = 3'd6,
    CZ_DIS    = 3'd7
  } cause_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_ON,
    ST_SCREG,
    ST_SCREST
  } sup_st_e;
endpackage

// File: rtl/pss_tick_ctr.sv
module pss_tick_ctr #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (clr)                          cnt <= '0;
    else if (tick && cnt != W'(LIMIT))     cnt <= cnt + W'(1);
  end

  assign done = (cnt == W'(LIMIT));
endmodule

// File: rtl/pss_fault_prio.sv
module pss_fault_prio #(
  parameter int CW        = 8,
  parameter int START_MS  = 16,
  parameter int UV_REC_MS = 18,
  parameter int OV_REC_MS = 9
) (
  input  logic          ot,
  input  logic          oc,
  input  logic          rev,
  input  logic          ov,
  input  logic          uv,
  output logic          any,
  output logic [2:0]    code,
  output logic [CW-1:0] need
);
  import pss_pkg::*;
  localparam int NF = 5;
  logic [NF-1:0] flags;

  // index 0 is the most urgent; code = index + 1
  assign flags = {uv, ov, rev, oc, ot};
  assign any   = |flags;

  always_comb begin
    code = CZ_PEND;
    for (int i = NF - 1; i >= 0; i--) begin
      if (flags[i]) code = 3'(i + 1);
    end
  end

  always_comb begin
    if (code == CZ_UVOLT)      need = CW'(UV_REC_MS);
    else if (code == CZ_OVOLT) need = CW'(OV_REC_MS);
    else                       need = CW'(START_MS);
  end
endmodule

// File: rtl/pwr_switch_supervisor.sv
module pwr_switch_supervisor #(
  parameter int START_MS  = 16,
  parameter int BLANK_MS  = 4,
  parameter int DEGL_MS   = 10,
  parameter int REV_MS    = 18,
  parameter int REG_MS    = 13,
  parameter int HICCUP_MS = 153,
  parameter int UV_REC_MS = 18,
  parameter int OV_REC_MS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       ms_tick_i,
  input  logic       ot_i,
  input  logic       oc_i,
  input  logic       sc_i,
  input  logic       rev_i,
  input  logic       ov_i,
  input  logic       uv_i,
  output logic       sw_on_o,
  output logic       fault_n_o,
  output logic [2:0] cause_o
);
  import pss_pkg::*;
  localparam int CW = $clog2(HICCUP_MS + START_MS + UV_REC_MS + OV_REC_MS + 1);

  logic blank_done, oc_q, rev_q;
  logic f_any;
  logic [2:0] f_code;
  logic [CW-1:0] f_need;

  sup_st_e st, st_n;
  logic [CW-1:0] ctr, ctr_n, need, need_n;
  logic recov, recov_n;

  // window counters: blanking after enable, over-current and reverse persistence
  pss_tick_ctr #(.LIMIT(BLANK_MS)) u_blank (
    .clk(clk), .rst_n(rst_n), .clr(!en_i), .tick(ms_tick_i), .done(blank_done));

  pss_tick_ctr #(.LIMIT(DEGL_MS)) u_degl (
    .clk(clk), .rst_n(rst_n), .clr(!en_i || !oc_i || !blank_done),
    .tick(ms_tick_i), .done(oc_q));

  pss_tick_ctr #(.LIMIT(REV_MS)) u_rev (
    .clk(clk), .rst_n(rst_n), .clr(!en_i || !rev_i),
    .tick(ms_tick_i), .done(rev_q));

  pss_fault_prio #(
    .CW(CW), .START_MS(START_MS), .UV_REC_MS(UV_REC_MS), .OV_REC_MS(OV_REC_MS)
  ) u_prio (
    .ot(ot_i), .oc(oc_q), .rev(rev_q), .ov(ov_i), .uv(uv_i),
    .any(f_any), .code(f_code), .need(f_need));

  always_comb begin
    st_n    = st;
    ctr_n   = ctr;
    need_n  = need;
    recov_n = recov;
    case (st)
      ST_OFF: begin
        st_n    = ST_WAIT;
        ctr_n   = '0;
        need_n  = CW'(START_MS);
        recov_n = 1'b0;
      end
      ST_WAIT: begin
        if (f_any) begin
          ctr_n   = '0;
          need_n  = f_need;
          recov_n = 1'b1;
        end else if (ms_tick_i) begin
          if (ctr + CW'(1) == need) begin
            st_n  = ST_ON;
            ctr_n = '0;
          end else begin
            ctr_n = ctr + CW'(1);
          end
        end
      end
      ST_ON: begin
        if (f_any) begin
          st_n = ST_WAIT; ctr_n = '0; need_n = f_need; recov_n = 1'b1;
        end else if (sc_i) begin
          st_n  = ST_SCREG;
          ctr_n = '0;
        end
      end
      ST_SCREG: begin
        if (f_any) begin
          st_n = ST_WAIT; ctr_n = '0; need_n = f_need; recov_n = 1'b1;
        end else if (ms_tick_i) begin
          if (ctr + CW'(1) == CW'(REG_MS)) st_n = ST_SCREST;
          ctr_n = ctr + CW'(1);
        end
      end
      ST_SCREST: begin
        if (f_any) begin
          st_n = ST_WAIT; ctr_n = '0; need_n = f_need; recov_n = 1'b1;
        end else if (ms_tick_i) begin
          if (ctr + CW'(1) == CW'(HICCUP_MS)) begin
            st_n  = ST_ON;
            ctr_n = '0;
          end else begin
            ctr_n = ctr + CW'(1);
          end
        end
      end
      default: st_n = ST_OFF;
    endcase
    if (!en_i) begin
      st_n    = ST_OFF;
      ctr_n   = '0;
      recov_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      ctr   <= '0;
      need  <= CW'(START_MS);
      recov <= 1'b0;
    end else begin
      st    <= st_n;
      ctr   <= ctr_n;
      need  <= need_n;
      recov <= recov_n;
    end
  end

  assign sw_on_o   = (st == ST_ON) || (st == ST_SCREG);
  assign fault_n_o = (st == ST_ON) || (st == ST_WAIT && !recov && !f_any);

  always_comb begin
    case (st)
      ST_OFF:              cause_o = CZ_DIS;
      ST_ON:               cause_o = CZ_NORMAL;
      ST_SCREG, ST_SCREST: cause_o = CZ_OCUR;
      default:             cause_o = f_any ? f_code : CZ_PEND;
    endcase
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       ot_i,
  input logic       ov_i,
  input logic       uv_i,
  input logic       sw_on_o,
  input logic       fault_n_o,
  input logic [2:0] cause_o
);
  a_r1_disable_state: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sw_on_o && !fault_n_o && cause_o == 3'd7));

  a_r2_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (ot_i || ov_i || uv_i)) |=> !sw_on_o);

  a_r3_turn_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_on_o) |-> $past(en_i && !ot_i && !ov_i && !uv_i));

  a_r4_flag_high_codes: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n_o |-> (cause_o == 3'd0 || cause_o == 3'd6));

  a_r8_conduct_codes: assert property (@(posedge clk) disable iff (!rst_n)
    sw_on_o |-> (cause_o == 3'd0 || cause_o == 3'd2));
endmodule

bind pwr_switch_supervisor pss_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .ot_i(ot_i), .ov_i(ov_i), .uv_i(uv_i),
  .sw_on_o(sw_on_o), .fault_n_o(fault_n_o), .cause_o(cause_o));

// File: tb/pwr_switch_supervisor_tb_top.sv
module pwr_switch_supervisor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, tick = 0, ot = 0, oc = 0, sc = 0, rev = 0, ov = 0, uv = 0;
  logic sw_on, fault_n;
  logic [2:0] cause;
  int checks = 0, fails = 0;

  localparam int T_START = 16, T_BLANK = 4, T_DEGL = 10, T_REV = 18;
  localparam int T_REG = 13, T_HIC = 153, T_UVR = 18, T_OVR = 9;

  always #4 clk = ~clk;

  pwr_switch_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ms_tick_i(tick),
    .ot_i(ot), .oc_i(oc), .sc_i(sc), .rev_i(rev), .ov_i(ov), .uv_i(uv),
    .sw_on_o(sw_on), .fault_n_o(fault_n), .cause_o(cause));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // expected value packs {switch, flag, cause}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {sw_on, fault_n, cause};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got sw=%0b flag=%0b cause=%0d, expected sw=%0b flag=%0b cause=%0d",
               req, act[4], act[3], act[2:0], exp[4], exp[3], exp[2:0]);
    end
  endtask

  function automatic logic [2:0] top_cause(input logic t, input logic o, input logic u);
    if (t) return 3'd1;
    if (o) return 3'd4;
    if (u) return 3'd5;
    return 3'd6;
  endfunction

  task automatic restart();
    en = 1'b0; step(2);
    en = 1'b1; step(2);
  endtask

  initial begin
    step(3);
    chk("R1 reset", {1'b0, 1'b0, 3'd7});
    rst_n = 1'b1; step(2);

    // R4 startup wait
    en = 1'b1; step(2);
    chk("R4 waiting", {1'b0, 1'b1, 3'd6});
    tk(T_START - 1);
    chk("R4 tick before on", {1'b0, 1'b1, 3'd6});
    tk(1);
    chk("R4 on", {1'b1, 1'b1, 3'd0});

    // R2/R3 over temperature, non-latching
    ot = 1'b1; step(2);
    chk("R2 over temperature", {1'b0, 1'b0, 3'd1});
    ot = 1'b0; step(1);
    tk(T_START - 1);
    chk("R3 still recovering", {1'b0, 1'b0, 3'd6});
    tk(1);
    chk("R3 auto recovery", {1'b1, 1'b1, 3'd0});

    // R9 undervoltage recovery
    uv = 1'b1; step(2);
    chk("R2 undervoltage", {1'b0, 1'b0, 3'd5});
    uv = 1'b0; step(1);
    tk(T_UVR - 1);
    chk("R9 uv before", {1'b0, 1'b0, 3'd6});
    tk(1);
    chk("R9 uv recovered", {1'b1, 1'b1, 3'd0});

    // R9 overvoltage recovery
    ov = 1'b1; step(2);
    chk("R2 overvoltage", {1'b0, 1'b0, 3'd4});
    ov = 1'b0; step(1);
    tk(T_OVR - 1);
    chk("R9 ov before", {1'b0, 1'b0, 3'd6});
    tk(1);
    chk("R9 ov recovered", {1'b1, 1'b1, 3'd0});

    // R5 priority sweep over every combination of immediate faults
    for (int m = 1; m < 8; m++) begin
      ot = m[0]; ov = m[1]; uv = m[2];
      step(2);
      chk("R5 priority", {1'b0, 1'b0, top_cause(m[0], m[1], m[2])});
    end
    ot = 1'b0; ov = 1'b0; uv = 1'b0; step(1);
    tk(T_START);
    chk("R5 recovery after sweep", {1'b1, 1'b1, 3'd0});

    // R7 over-current persistence
    oc = 1'b1; step(1);
    tk(T_DEGL - 1);
    chk("R7 oc not yet", {1'b1, 1'b1, 3'd0});
    tk(1);
    chk("R7 oc fault", {1'b0, 1'b0, 3'd2});
    // R5 over temperature outranks over current
    ot = 1'b1; step(2);
    chk("R5 ot over oc", {1'b0, 1'b0, 3'd1});
    ot = 1'b0; oc = 1'b0; step(1);
    tk(T_START);
    chk("R7 oc recovered", {1'b1, 1'b1, 3'd0});

    // R10 reverse current persistence
    rev = 1'b1; step(1);
    tk(T_REV - 1);
    chk("R10 short reverse ignored", {1'b1, 1'b1, 3'd0});
    tk(1);
    chk("R10 reverse fault", {1'b0, 1'b0, 3'd3});
    rev = 1'b0; step(1);
    tk(T_START);
    chk("R10 reverse recovered", {1'b1, 1'b1, 3'd0});

    // R8 short-circuit hiccup
    sc = 1'b1; step(2);
    chk("R8 regulating", {1'b1, 1'b0, 3'd2});
    tk(T_REG - 1);
    chk("R8 still regulating", {1'b1, 1'b0, 3'd2});
    tk(1);
    chk("R8 rest", {1'b0, 1'b0, 3'd2});
    tk(T_HIC - T_REG - 1);
    chk("R8 rest before retry", {1'b0, 1'b0, 3'd2});
    tk(1);
    chk("R8 retry pulse", {1'b1, 1'b0, 3'd2});
    sc = 1'b0;
    tk(T_HIC);
    chk("R8 short gone", {1'b1, 1'b1, 3'd0});

    // R1 disable, R6 blanking
    en = 1'b0; step(2);
    chk("R1 disabled", {1'b0, 1'b0, 3'd7});
    oc = 1'b1; en = 1'b1; step(2);
    tk(T_BLANK + T_DEGL - 1);
    chk("R6 blank delays oc", {1'b0, 1'b1, 3'd6});
    tk(1);
    chk("R6 oc after blank", {1'b0, 1'b0, 3'd2});
    oc = 1'b0; step(1);
    tk(T_START);
    chk("R6 recovered", {1'b1, 1'b1, 3'd0});

    // R1 abort a count in progress
    restart();
    tk(10);
    en = 1'b0; step(2);
    chk("R1 abort", {1'b0, 1'b0, 3'd7});
    en = 1'b1; step(2);
    tk(T_START - 1);
    chk("R1 fresh count", {1'b0, 1'b1, 3'd6});
    tk(1);
    chk("R1 on after fresh count", {1'b1, 1'b1, 3'd0});

    // R4 interruption restarts the count (undervoltage glitch)
    restart();
    tk(10);
    uv = 1'b1; step(1);
    uv = 1'b0; step(1);
    tk(T_UVR - 1);
    chk("R4 restarted count", {1'b0, 1'b0, 3'd6});
    tk(1);
    chk("R4 on after restart", {1'b1, 1'b1, 3'd0});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule